// File: doc/BRIEF.md
# Balanced Adder-Tree Population Counter

This block reports how many bits of a wide input word are set, as an unsigned binary count. It is purely combinational: there is no clock, no reset and no state, and the count follows the input within one evaluation.

The input is first zero-extended to the next power-of-two width. That padded word is then split recursively into halves down to single bits. A single bit is worth 0 or 1, and each node above the leaves adds the counts of its two halves. The result is a balanced tree whose depth is the base-2 logarithm of the padded width. It has no serial accumulation chain and no signal that feeds back on itself. With the default 2023-bit input the padded width is 2048, so the tree has 11 adder levels and 2047 adders. At level k above the leaves every partial sum is k+1 bits wide, so no partial sum can overflow.

The block is meant to be dropped into wider datapaths that need a set-bit count, for example for weight, fill-level or vote counting, with the width set by one parameter.

Top module: `popcount_tree`

## Requirements
- R1: For the default width of 2023 bits, `cnt` equals the number of set bits in `din` for any input pattern.
- R2: With L = ceil(log2(WIDTH)) (L = 0 when WIDTH is 1), the output `cnt` is L+1 bits wide: 12 bits for WIDTH 2023, 7 bits for WIDTH 37 and 7 bits for WIDTH 64.
- R3: When every bit of `din` is 0, `cnt` is 0.
- R4: When every bit of `din` is 1, `cnt` equals WIDTH (2023 at the default width).
- R5: When exactly one bit of `din` is set, whether at position 0, at position WIDTH-1 or anywhere between, `cnt` is 1.
- R6: For a width that is not a power of two (WIDTH 37), `cnt` equals the number of set bits in `din`; the zero padding up to 64 adds nothing to the count.
- R7: For a width that is already a power of two (WIDTH 64), `cnt` equals the number of set bits in `din`, and no padding is applied.
- R8: `cnt` never exceeds WIDTH, and bit 0 of `cnt` always equals the XOR of all bits of `din`.
- R9: The block is combinational: after `din` changes, `cnt` shows the new count without any clock edge, within the same cycle.
- R10: For WIDTH 1 the output is 1 bit wide and equals the input bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | WIDTH | Word whose set bits are counted |
| cnt | output | ceil(log2(WIDTH))+1 | Unsigned number of set bits in `din` |

## Verification
On every change of the input, the assertions check the properties that follow from the count alone. The count is within range. An all-clear input gives zero, an all-set input gives the full width, and a lone set bit gives one. The low bit of the count matches the parity of the input. The exact count for arbitrary patterns, the width of the output port, and the behaviour at several widths (padded, unpadded and the single-bit case) are shown only by the bench. It compares each width's output against a bit-by-bit reference count over random sparse, dense and uniform vectors.

// File: rtl/popcount_pkg.sv
package popcount_pkg;

    // Number of halving levels needed to cover w bits (0 for a single bit).
    function automatic int tree_levels(input int w);
        return (w > 1) ? $clog2(w) : 0;
    endfunction

    // Width of a padded word for w input bits.
    function automatic int padded_width(input int w);
        return 1 << tree_levels(w);
    endfunction

endpackage

// File: rtl/pc_pad.sv
module pc_pad #(
    parameter int IN_W  = 2023,
    parameter int OUT_W = 2048
) (
    input  logic [IN_W-1:0]  src,
    output logic [OUT_W-1:0] dst
);

    generate
        if (OUT_W > IN_W) begin : g_extend
            localparam int FILL = OUT_W - IN_W;
            assign dst = {{FILL{1'b0}}, src};
        end else begin : g_pass
            assign dst = src;
        end
    endgenerate

endmodule

// File: rtl/pc_node.sv
// One node of the counting tree. A node at level LVL covers 2**LVL bits and
// yields a sum of LVL+1 bits; it instantiates two nodes of level LVL-1.
module pc_node #(
    parameter int LVL = 11
) (
    input  logic [(1<<LVL)-1:0] bits,
    output logic [LVL:0]        sum
);

    generate
        if (LVL == 0) begin : g_leaf
            assign sum = bits;
        end else begin : g_split
            localparam int HALF = 1 << (LVL - 1);

            logic [LVL-1:0] sum_hi;
            logic [LVL-1:0] sum_lo;

            pc_node #(.LVL(LVL - 1)) u_hi (
                .bits (bits[2*HALF-1:HALF]),
                .sum  (sum_hi)
            );

            pc_node #(.LVL(LVL - 1)) u_lo (
                .bits (bits[HALF-1:0]),
                .sum  (sum_lo)
            );

            assign sum = {1'b0, sum_hi} + {1'b0, sum_lo};
        end
    endgenerate

endmodule

// File: rtl/popcount_tree.sv
module popcount_tree #(
    parameter  int WIDTH  = 2023,
    localparam int LEVELS = popcount_pkg::tree_levels(WIDTH),
    localparam int CNT_W  = LEVELS + 1
) (
    input  logic [WIDTH-1:0] din,
    output logic [CNT_W-1:0] cnt
);

    localparam int PAD_W = popcount_pkg::padded_width(WIDTH);

    logic [PAD_W-1:0] din_padded;

    pc_pad #(
        .IN_W  (WIDTH),
        .OUT_W (PAD_W)
    ) u_pad (
        .src (din),
        .dst (din_padded)
    );

    pc_node #(.LVL(LEVELS)) u_root (
        .bits (din_padded),
        .sum  (cnt)
    );

endmodule

// File: rtl/popcount_tree_chk.sv
module popcount_tree_chk #(
    parameter int WIDTH = 2023,
    parameter int CNT_W = 12
) (
    input logic [WIDTH-1:0] din,
    input logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(WIDTH);

    always_comb begin
        if (!$isunknown(din) && !$isunknown(cnt)) begin
            // R8
            range_chk: assert (cnt <= FULL);
            // R8
            parity_chk: assert (cnt[0] == ^din);
            // R3
            zero_chk: assert (!(din == '0) || cnt == '0);
            // R4
            full_chk: assert (!(&din) || cnt == FULL);
            // R5
            single_chk: assert (!($onehot0(din) && din != '0) || cnt == CNT_W'(1));
        end
    end

endmodule

bind popcount_tree popcount_tree_chk #(
    .WIDTH (WIDTH),
    .CNT_W (CNT_W)
) u_chk (
    .din (din),
    .cnt (cnt)
);

// File: tb/test_popcount_tree.sv
module test_popcount_tree;

    localparam int WA = 2023;
    localparam int WB = 37;
    localparam int WC = 64;
    localparam int WD = 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [WA-1:0] din_a;
    logic [WB-1:0] din_b;
    logic [WC-1:0] din_c;
    logic [WD-1:0] din_d;
    logic [11:0]   cnt_a;
    logic [6:0]    cnt_b;
    logic [6:0]    cnt_c;
    logic [0:0]    cnt_d;

    popcount_tree #(.WIDTH(WA)) i_popcount_tree (.din(din_a), .cnt(cnt_a));
    popcount_tree #(.WIDTH(WB)) i_popcount_tree_b (.din(din_b), .cnt(cnt_b));
    popcount_tree #(.WIDTH(WC)) i_popcount_tree_c (.din(din_c), .cnt(cnt_c));
    popcount_tree #(.WIDTH(WD)) i_popcount_tree_d (.din(din_d), .cnt(cnt_d));

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    function automatic int ref_count(input logic [2047:0] v, input int w);
        int c = 0;
        for (int i = 0; i < w; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic [2047:0] rand_vec(input int mode);
        logic [2047:0] v;
        for (int k = 0; k < 64; k++) begin
            case (mode)
                1:       v[k*32 +: 32] = $urandom() & $urandom() & $urandom();
                2:       v[k*32 +: 32] = $urandom() | $urandom() | $urandom();
                default: v[k*32 +: 32] = $urandom();
            endcase
        end
        return v;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic apply(input logic [2047:0] v);
        @(posedge clk);
        #1;
        din_a = v[WA-1:0];
        din_b = v[WB-1:0];
        din_c = v[WC-1:0];
        din_d = v[WD-1:0];
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic [2047:0] v);
        check({req, " w2023"}, int'(cnt_a), ref_count(v, WA));
        check({req, " w37"},   int'(cnt_b), ref_count(v, WB));
        check({req, " w64"},   int'(cnt_c), ref_count(v, WC));
        check({req, " w1"},    int'(cnt_d), ref_count(v, WD));
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [2047:0] v;
        void'($urandom(32'd20240611));
        din_a = '0; din_b = '0; din_c = '0; din_d = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R2: output widths
        check("R2 w2023 width", $bits(cnt_a), 12);
        check("R2 w37 width",   $bits(i_popcount_tree_b.cnt), 7);
        check("R2 w64 width",   $bits(i_popcount_tree_c.cnt), 7);
        check("R10 w1 width",   $bits(i_popcount_tree_d.cnt), 1);

        // R3: all clear
        v = '0;
        apply(v);
        check("R3 zero w2023", int'(cnt_a), 0);
        check("R3 zero w37",   int'(cnt_b), 0);
        check("R10 zero w1",   int'(cnt_d), 0);

        // R4: all set
        v = '1;
        apply(v);
        check("R4 full w2023", int'(cnt_a), WA);
        check("R6 full w37",   int'(cnt_b), WB);
        check("R7 full w64",   int'(cnt_c), WC);
        check("R10 full w1",   int'(cnt_d), 1);

        // R5: lone set bit at lowest and highest positions
        v = '0; v[0] = 1'b1;
        apply(v);
        check("R5 low w2023", int'(cnt_a), 1);
        check("R5 low w37",   int'(cnt_b), 1);
        v = '0; v[WA-1] = 1'b1;
        apply(v);
        check("R5 high w2023", int'(cnt_a), 1);
        v = '0; v[WB-1] = 1'b1;
        apply(v);
        check("R5 high w37", int'(cnt_b), 1);
        v = '0; v[WC-1] = 1'b1;
        apply(v);
        check("R5 high w64", int'(cnt_c), 1);

        // R6: bits above WIDTH in the stimulus must not be counted by w37
        v = '0; v[WB] = 1'b1; v[WB+5] = 1'b1; v[3] = 1'b1;
        apply(v);
        check("R6 beyond width w37", int'(cnt_b), 1);

        // R1: small example word
        v = '0; v[4:0] = 5'b01010;
        apply(v);
        check("R1 example w2023", int'(cnt_a), 2);

        // R9: new input seen within the same cycle, no clock edge between
        v = rand_vec(0);
        @(negedge clk);
        din_a = v[WA-1:0];
        #1;
        check("R9 same-cycle w2023", int'(cnt_a), ref_count(v, WA));

        // R1 R6 R7 R8 R10: random uniform, sparse and dense words
        for (int it = 0; it < 300; it++) begin
            v = rand_vec(it % 3);
            apply(v);
            check_all("R1 R6 R7 random", v);
            check("R8 parity w2023", int'(cnt_a[0]), ref_count(v, WA) % 2);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule